// File: doc/BRIEF.md
# Interval-Shard Traversal Sequencer

This block is the control engine for one pass of an interval-partitioned graph update. Vertices are split into P intervals and edges into P x P sub-shards. For each destination interval the sequencer loads that interval into the write cache. It then loads source interval 0 into the active read bank and walks the source intervals in ascending order, starting one sub-shard update per step. While step i runs, it fetches source interval i+1 into the idle read bank, so vertex loading overlaps with computation. When the last step is done it writes the destination interval back, then moves to the next destination.

Each activity is driven through a one-cycle request and a one-cycle done pulse. A step retires only when three things have completed: the compute lanes, the edge stream and the prefetch of the next source interval. The step therefore takes as long as the slowest of the three. In multi-chip mode a barrier request precedes each destination load and each prefetch. When a pass ends, the sequencer starts another pass if any lane flagged a changed vertex during the pass. Otherwise it raises a finished flag.

Top module: `isq_seq`

## Requirements
- R1: After reset no request output is high, and busy_o, finished_o and iter_cnt_o are all zero.
- R2: start_i is taken only while idle. It latches p_count_i as P and multi_chip_i as the mode. A start_i pulse, or a change of p_count_i or multi_chip_i, while busy has no effect on the command sequence.
- R3: For each destination j = 0..P-1 in turn, the order is: load destination (load_dst_o=1, load_idx_o=j), then load source 0 (load_dst_o=0) into the current bank, then P update requests with upd_src_o = 0..P-1 and upd_dst_o = j.
- R4: For every step i < P-1, a source load of interval i+1 is issued. Its load_bank_o is the inverse of that step's upd_bank_o. In single-chip mode it is issued in the same cycle as the update request. The last step of a destination has no prefetch.
- R5: A step retires in the cycle after the last of its compute done, edge done and prefetch load done. The next command (update or save) is visible one cycle after that done. A done in the same cycle as its request is accepted.
- R6: The read bank flips exactly once per retired step. upd_bank_o alternates across successive steps, including across destination boundaries, and starts at 0 after reset.
- R7: After the last step of destination j, save_req_o pulses with save_idx_o = j. The next destination's first command follows one cycle after save_done_i.
- R8: In multi-chip mode a sync request precedes each destination load and each prefetch. The load is issued in the cycle after sync_done_i, and sync and load requests never coincide.
- R9: After the last save of a pass, iter_cnt_o increments. If changed_i was high in any cycle of that pass, a new pass starts at destination 0. Otherwise busy_o falls and finished_o rises in the same cycle.
- R10: With P = 1 each destination has a single step with no prefetch, and the step retires on compute and edge done alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run (idle only) |
| multi_chip_i | input | 1 | Enable barrier requests |
| p_count_i | input | IW | Number of intervals P (1..2^IW-1) |
| changed_i | input | 1 | A lane changed a vertex this cycle |
| sync_req_o | output | 1 | Barrier request pulse |
| sync_done_i | input | 1 | Barrier release pulse |
| load_req_o | output | 1 | Interval load request pulse |
| load_dst_o | output | 1 | 1: destination into write cache, 0: source into read bank |
| load_idx_o | output | IW | Interval index to load |
| load_bank_o | output | 1 | Read bank for a source load |
| load_done_i | input | 1 | Load finished pulse |
| upd_req_o | output | 1 | Sub-shard update start pulse |
| upd_src_o | output | IW | Source interval of the update |
| upd_dst_o | output | IW | Destination interval of the update |
| upd_bank_o | output | 1 | Read bank holding the source interval |
| cmp_done_i | input | 1 | Compute lanes finished pulse |
| edge_done_i | input | 1 | Edge stream finished pulse |
| save_req_o | output | 1 | Destination write-back request pulse |
| save_idx_o | output | IW | Interval to write back |
| save_done_i | input | 1 | Write-back finished pulse |
| busy_o | output | 1 | A run is in progress |
| finished_o | output | 1 | Last run converged |
| iter_cnt_o | output | CW | Passes completed in this run |

## Verification
The embedded assertions check four things on every cycle: bank flips happen only when a step retires, busy and finished are mutually exclusive, sync and load requests are never issued together, and update sources stay below P. They also check that save pulses last one cycle and that loop counters never advance past their last value. Command order, field values, the one-cycle gap after the slowest done, convergence-driven repetition, the P = 1 corner and the way a start or a parameter change during a run is ignored are shown only by the bench scenarios. These compare every issued command against a model-built queue and time-stamp each done.

// File: rtl/isq_pkg.sv
package isq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DSYNC,
    ST_DLOAD,
    ST_SLOAD,
    ST_STEP,
    ST_SAVE
  } st_e;
endpackage

// File: rtl/isq_idx_ctr.sv
module isq_idx_ctr #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] lim_i,
  output logic [W-1:0] val_o,
  output logic         last_o
);
  logic [W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_q <= '0;
    else if (clr_i) val_q <= '0;
    else if (inc_i) val_q <= val_q + 1'b1;
  end

  assign val_o  = val_q;
  assign last_o = (val_q == lim_i - 1'b1);

  // R3
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |-> !last_o);
endmodule

// File: rtl/isq_step_join.sv
module isq_step_join (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic no_pf_i,
  input  logic active_i,
  input  logic cmp_done_i,
  input  logic edge_done_i,
  input  logic vtx_done_i,
  output logic all_o
);
  logic cmp_q, edge_q, vtx_q;

  // Re-arming clears the three done flags; a step with no prefetch starts with vertex done.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= 1'b0;
      edge_q <= 1'b0;
      vtx_q  <= 1'b0;
    end else if (arm_i) begin
      cmp_q  <= 1'b0;
      edge_q <= 1'b0;
      vtx_q  <= no_pf_i;
    end else if (active_i) begin
      cmp_q  <= cmp_q  | cmp_done_i;
      edge_q <= edge_q | edge_done_i;
      vtx_q  <= vtx_q  | vtx_done_i;
    end
  end

  assign all_o = active_i & (cmp_q | cmp_done_i) & (edge_q | edge_done_i)
                          & (vtx_q | vtx_done_i);

  // R5
  cmp_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmp_q) |-> $past(active_i));
  // R5
  edge_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(edge_q) |-> $past(active_i));
endmodule

// File: rtl/isq_seq.sv
module isq_seq
  import isq_pkg::*;
#(
  parameter int IW = 4,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          multi_chip_i,
  input  logic [IW-1:0] p_count_i,
  input  logic          changed_i,
  output logic          sync_req_o,
  input  logic          sync_done_i,
  output logic          load_req_o,
  output logic          load_dst_o,
  output logic [IW-1:0] load_idx_o,
  output logic          load_bank_o,
  input  logic          load_done_i,
  output logic          upd_req_o,
  output logic [IW-1:0] upd_src_o,
  output logic [IW-1:0] upd_dst_o,
  output logic          upd_bank_o,
  input  logic          cmp_done_i,
  input  logic          edge_done_i,
  output logic          save_req_o,
  output logic [IW-1:0] save_idx_o,
  input  logic          save_done_i,
  output logic          busy_o,
  output logic          finished_o,
  output logic [CW-1:0] iter_cnt_o
);
  st_e           st_q;
  logic [IW-1:0] p_q;
  logic          multi_q, chg_q, bank_q, pf_sync_q, fin_q;
  logic [CW-1:0] iter_q;

  logic          sync_q, ld_q, ld_dst_q, ld_bank_q, up_q, up_bank_q, sv_q;
  logic [IW-1:0] ld_idx_q, up_src_q, up_dst_q, sv_idx_q;

  logic [IW-1:0] s_val, d_val, arm_src;
  logic          s_last, d_last, s_clr, s_inc, d_clr, d_inc;
  logic          arm, arm_last, cur_bank, step_done, vtx_done, save_ev;

  assign save_ev   = (st_q == ST_SAVE) && save_done_i;
  assign d_clr     = ((st_q == ST_IDLE) && start_i) || (save_ev && d_last);
  assign d_inc     = save_ev && !d_last;
  assign s_clr     = d_clr || save_ev;
  assign s_inc     = (st_q == ST_STEP) && step_done && !s_last;
  assign arm       = ((st_q == ST_SLOAD) && load_done_i) || s_inc;
  assign arm_src   = (st_q == ST_STEP) ? s_val + 1'b1 : s_val;
  assign arm_last  = (arm_src == p_q - 1'b1);
  assign cur_bank  = (st_q == ST_STEP) ? ~bank_q : bank_q;
  assign vtx_done  = (st_q == ST_STEP) && load_done_i && !pf_sync_q;

  isq_idx_ctr #(.W(IW)) u_src_ctr (
    .clk_i, .rst_ni, .clr_i(s_clr), .inc_i(s_inc), .lim_i(p_q),
    .val_o(s_val), .last_o(s_last)
  );

  isq_idx_ctr #(.W(IW)) u_dst_ctr (
    .clk_i, .rst_ni, .clr_i(d_clr), .inc_i(d_inc), .lim_i(p_q),
    .val_o(d_val), .last_o(d_last)
  );

  isq_step_join u_join (
    .clk_i, .rst_ni,
    .arm_i(arm), .no_pf_i(arm_last), .active_i(st_q == ST_STEP),
    .cmp_done_i, .edge_done_i, .vtx_done_i(vtx_done),
    .all_o(step_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      p_q       <= '0;
      multi_q   <= 1'b0;
      chg_q     <= 1'b0;
      bank_q    <= 1'b0;
      pf_sync_q <= 1'b0;
      fin_q     <= 1'b0;
      iter_q    <= '0;
      sync_q    <= 1'b0;
      ld_q      <= 1'b0;
      ld_dst_q  <= 1'b0;
      ld_idx_q  <= '0;
      ld_bank_q <= 1'b0;
      up_q      <= 1'b0;
      up_src_q  <= '0;
      up_dst_q  <= '0;
      up_bank_q <= 1'b0;
      sv_q      <= 1'b0;
      sv_idx_q  <= '0;
    end else begin
      sync_q <= 1'b0;
      ld_q   <= 1'b0;
      up_q   <= 1'b0;
      sv_q   <= 1'b0;
      if (st_q != ST_IDLE && changed_i) chg_q <= 1'b1;

      if (arm) begin
        up_q      <= 1'b1;
        up_src_q  <= arm_src;
        up_dst_q  <= d_val;
        up_bank_q <= cur_bank;
        if (!arm_last) begin
          if (multi_q) begin
            sync_q    <= 1'b1;
            pf_sync_q <= 1'b1;
          end else begin
            ld_q      <= 1'b1;
            ld_dst_q  <= 1'b0;
            ld_idx_q  <= arm_src + 1'b1;
            ld_bank_q <= ~cur_bank;
          end
        end
      end

      unique case (st_q)
        ST_IDLE: if (start_i) begin
          p_q     <= p_count_i;
          multi_q <= multi_chip_i;
          chg_q   <= 1'b0;
          fin_q   <= 1'b0;
          iter_q  <= '0;
          if (multi_chip_i) begin
            sync_q <= 1'b1;
            st_q   <= ST_DSYNC;
          end else begin
            ld_q     <= 1'b1;
            ld_dst_q <= 1'b1;
            ld_idx_q <= '0;
            st_q     <= ST_DLOAD;
          end
        end
        ST_DSYNC: if (sync_done_i) begin
          ld_q     <= 1'b1;
          ld_dst_q <= 1'b1;
          ld_idx_q <= d_val;
          st_q     <= ST_DLOAD;
        end
        ST_DLOAD: if (load_done_i) begin
          ld_q      <= 1'b1;
          ld_dst_q  <= 1'b0;
          ld_idx_q  <= '0;
          ld_bank_q <= bank_q;
          st_q      <= ST_SLOAD;
        end
        ST_SLOAD: if (load_done_i) st_q <= ST_STEP;
        ST_STEP: begin
          // barrier released: prefetch the next source into the idle bank
          if (pf_sync_q && sync_done_i) begin
            pf_sync_q <= 1'b0;
            ld_q      <= 1'b1;
            ld_dst_q  <= 1'b0;
            ld_idx_q  <= s_val + 1'b1;
            ld_bank_q <= ~bank_q;
          end
          if (step_done) begin
            bank_q <= ~bank_q;
            if (s_last) begin
              sv_q     <= 1'b1;
              sv_idx_q <= d_val;
              st_q     <= ST_SAVE;
            end
          end
        end
        ST_SAVE: if (save_done_i) begin
          if (d_last) iter_q <= iter_q + 1'b1;
          if (d_last && !(chg_q || changed_i)) begin
            fin_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else begin
            if (d_last) chg_q <= 1'b0;
            if (multi_q) begin
              sync_q <= 1'b1;
              st_q   <= ST_DSYNC;
            end else begin
              ld_q     <= 1'b1;
              ld_dst_q <= 1'b1;
              ld_idx_q <= d_last ? '0 : d_val + 1'b1;
              st_q     <= ST_DLOAD;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sync_req_o  = sync_q;
  assign load_req_o  = ld_q;
  assign load_dst_o  = ld_dst_q;
  assign load_idx_o  = ld_idx_q;
  assign load_bank_o = ld_bank_q;
  assign upd_req_o   = up_q;
  assign upd_src_o   = up_src_q;
  assign upd_dst_o   = up_dst_q;
  assign upd_bank_o  = up_bank_q;
  assign save_req_o  = sv_q;
  assign save_idx_o  = sv_idx_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign finished_o  = fin_q;
  assign iter_cnt_o  = iter_q;

  // R6
  bank_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_q != $past(bank_q)) |-> $past(st_q == ST_STEP));
  // R9
  fin_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finished_o |-> !busy_o);
  // R8
  sync_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_req_o |-> !load_req_o);
  // R3
  src_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_req_o |-> (upd_src_o < p_q));
  // R7
  save_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_req_o |=> !save_req_o);
endmodule

// File: tb/isq_seq_tb.sv
module isq_seq_tb;
  localparam int IW = 4;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, multi_chip_i = 1'b0, changed_i = 1'b0;
  logic [IW-1:0] p_count_i = '0;
  logic sync_done_i = 1'b0, load_done_i = 1'b0, cmp_done_i = 1'b0;
  logic edge_done_i = 1'b0, save_done_i = 1'b0;
  logic sync_req_o, load_req_o, load_dst_o, load_bank_o, upd_req_o, upd_bank_o;
  logic save_req_o, busy_o, finished_o;
  logic [IW-1:0] load_idx_o, upd_src_o, upd_dst_o, save_idx_o;
  logic [CW-1:0] iter_cnt_o;

  always #10 clk = ~clk;

  isq_seq #(.IW(IW), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .multi_chip_i, .p_count_i, .changed_i,
    .sync_req_o, .sync_done_i, .load_req_o, .load_dst_o, .load_idx_o, .load_bank_o,
    .load_done_i, .upd_req_o, .upd_src_o, .upd_dst_o, .upd_bank_o, .cmp_done_i,
    .edge_done_i, .save_req_o, .save_idx_o, .save_done_i, .busy_o, .finished_o,
    .iter_cnt_o
  );

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  int cyc = 0, gate = 0, kk = 0, saves = 0;
  int cdue = -1, edue = -1, ldue = -1, sdue = -1, vdue = -1, pfs = -1;
  int sc_p = 1, sc_chg = 0, mid_at = -1;
  bit sc_multi = 0, in_step = 0, go_req = 0, live = 0, all_done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 sync, 1 dest load, 2 source load, 3 update, 4 save
  function automatic int enc(input int kind, input int a, input int b, input int bank);
    return kind * 100000 + a * 1000 + b * 10 + bank;
  endfunction

  task automatic cmp_cmd(input int code, input string req);
    int e;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
    chk(code == e, req, code, e);
  endtask

  task automatic build(input int p, input bit multi, input int iters);
    int bank;
    bank = 0;
    exp_q.delete();
    for (int it = 0; it < iters; it++)
      for (int j = 0; j < p; j++) begin
        if (multi) exp_q.push_back(enc(0, 0, 0, 0));
        exp_q.push_back(enc(1, j, 0, 0));
        exp_q.push_back(enc(2, 0, 0, bank));
        for (int i = 0; i < p; i++) begin
          exp_q.push_back(enc(3, i, j, bank));
          if (i < p - 1) begin
            if (multi) exp_q.push_back(enc(0, 0, 0, 0));
            exp_q.push_back(enc(2, i + 1, 0, 1 - bank));
          end
          bank = 1 - bank;
        end
        exp_q.push_back(enc(4, j, 0, 0));
      end
  endtask

  // environment: observes requests, drives done pulses with varying latency
  always @(negedge clk) begin
    int lat;
    cyc++;
    start_i <= 1'b0;
    if (live && rst_n) begin
      chk(!(busy_o && finished_o), "R9", busy_o, 0);
      if (upd_req_o) begin
        cmp_cmd(enc(3, upd_src_o, upd_dst_o, upd_bank_o), "R3/R6");
        chk(cyc == gate + 1, "R5", cyc, gate + 1);
        cdue = cyc + (kk * 3) % 5;
        edue = cyc + (kk * 7 + 1) % 6;
        gate = (cdue > edue) ? cdue : edue;
        in_step = 1;
        kk++;
      end
      if (sync_req_o) begin
        cmp_cmd(enc(0, 0, 0, 0), "R8");
        chk(!load_req_o, "R8", load_req_o, 0);
        sdue = cyc + kk % 3;
        if (!in_step) begin
          chk(cyc == gate + 1, "R8", cyc, gate + 1);
          gate = sdue;
        end else pfs = sdue;
        kk++;
      end
      if (load_req_o) begin
        lat = (kk * 5 + 2) % 7;
        ldue = cyc + lat;
        if (load_dst_o) begin
          cmp_cmd(enc(1, load_idx_o, 0, 0), "R3");
          chk(cyc == gate + 1, "R7", cyc, gate + 1);
          gate = ldue;
        end else if (!in_step) begin
          cmp_cmd(enc(2, load_idx_o, 0, load_bank_o), "R3");
          chk(cyc == gate + 1, "R5", cyc, gate + 1);
          gate = ldue;
        end else begin
          cmp_cmd(enc(2, load_idx_o, 0, load_bank_o), "R4");
          if (sc_multi) chk(cyc == pfs + 1, "R8", cyc, pfs + 1);
          else chk(upd_req_o, "R4", upd_req_o, 1);
          if (ldue > gate) gate = ldue;
        end
        kk++;
      end
      if (save_req_o) begin
        cmp_cmd(enc(4, save_idx_o, 0, 0), "R7");
        chk(cyc == gate + 1, "R5", cyc, gate + 1);
        vdue = cyc + kk % 4;
        gate = vdue;
        in_step = 0;
        saves++;
        kk++;
      end
      if (cyc == mid_at) begin
        start_i <= 1'b1;
        p_count_i <= IW'(sc_p + 2);
        multi_chip_i <= ~sc_multi;
      end
    end
    if (go_req) begin
      go_req = 0;
      start_i <= 1'b1;
      gate = cyc;
      live = 1;
    end
    cmp_done_i  <= (cdue == cyc);
    edge_done_i <= (edue == cyc);
    load_done_i <= (ldue == cyc);
    sync_done_i <= (sdue == cyc);
    save_done_i <= (vdue == cyc);
    changed_i   <= (cdue == cyc) && ((saves / sc_p) < sc_chg);
  end

  task automatic scenario(input int p, input bit multi, input int chg, input bit mid);
    @(negedge clk);
    rst_n = 1'b0;
    live = 0;
    in_step = 0; saves = 0;
    cdue = -1; edue = -1; ldue = -1; sdue = -1; vdue = -1; pfs = -1;
    sc_p = p; sc_multi = multi; sc_chg = chg;
    build(p, multi, chg + 1);
    p_count_i = IW'(p);
    multi_chip_i = multi;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk({sync_req_o, load_req_o, upd_req_o, save_req_o, busy_o, finished_o} == 6'b0,
        "R1", {sync_req_o, load_req_o, upd_req_o, save_req_o, busy_o, finished_o}, 0);
    chk(iter_cnt_o == 0, "R1", iter_cnt_o, 0);
    @(posedge clk);
    mid_at = mid ? cyc + 25 : -1;
    go_req = 1;
    wait (finished_o === 1'b1);
    @(negedge clk);
    // R9 convergence, R2 latched parameters
    chk(!busy_o, "R9", busy_o, 0);
    chk(iter_cnt_o == CW'(chg + 1), "R9", iter_cnt_o, chg + 1);
    chk(exp_q.size() == 0, "R2", exp_q.size(), 0);
    live = 0;
    mid_at = -1;
  endtask

  initial begin
    scenario(3, 1'b0, 1, 1'b0);
    scenario(2, 1'b1, 0, 1'b0);
    scenario(1, 1'b0, 0, 1'b0); // R10
    scenario(4, 1'b1, 1, 1'b1); // R2 start and inputs changed mid-run
    scenario(3, 1'b0, 2, 1'b1);
    all_done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!all_done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule